// File: doc/BRIEF.md
# Capture and Dual-Compare PWM Timer

This block is a 16-bit up-counter with two value registers, called the period register and the duty register. Each one works either as a compare register or as a capture register. In compare mode the period register sets where the counter returns to zero, and the duty register sets how long the PWM output stays high in each period. In capture mode a register takes the counter value when a chosen edge appears on the capture pin. The capture edge can be rising, falling, both or none.

The counter advances on ticks. A tick comes either from an internal enable input or from rising edges of an external clock pin, which is sampled in the block's own clock domain. Software uses a small register port to configure the block and to read the counter and the captured values. Each channel has a one-cycle interrupt pulse. A second capture that arrives before software has read the first one is recorded as an overrun.

Top module: `cc_pwm_timer`

## Requirements
- R1: When the run bit (control bit 0) is 1, the counter adds one on each tick and rolls over from 65535 to 0 while the period register is in capture mode. When the run bit is 0, the counter holds its value.
- R2: Control bit 1 selects the tick source. With 0, ticks come from `tick_en`. With 1, each rising edge of `ext_clk` gives one tick and `tick_en` is ignored.
- R3: Register addresses are: 0 control (8 bits), 1 period, 2 duty, 3 counter, 4 status. Writing the counter address loads the counter, and this load takes priority over a tick. Reading an unmapped address returns 0.
- R4: When control bit 2 is 0, the period register is in compare mode. On a tick where the counter equals the period value, the counter goes to 0 and `irq_a` pulses for one cycle.
- R5: When control bit 3 is 0, `pwm_out` is high exactly while the counter is below the duty value. When control bit 3 is 1, `pwm_out` stays low.
- R6: Edge select fields are control bits 5:4 for the period register and bits 7:6 for the duty register. The codes are 00 none, 01 rising, 10 falling, 11 both. A register in capture mode (control bit 2 or 3 set to 1) latches the counter on each selected edge of `cap_in`.
- R7: `cap_in` passes through two synchronising flip-flops. An edge seen at clock edge k is captured, and its interrupt pulse raised for one cycle, at clock edge k+2.
- R8: A capture into a register that has not been read since its last capture sets that channel's overrun bit (status bit 0 for period, bit 1 for duty). Reading the status register clears both bits. Reading the value register clears the pending state.
- R9: After reset, all registers and the counter are 0, and `pwm_out`, `irq_a` and `irq_b` are low.
- R10: When control bit 3 is 0, `irq_b` pulses for one cycle on each tick where the counter equals the duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Internal count enable |
| ext_clk | input | 1 | External count clock pin, asynchronous |
| cap_in | input | 1 | Capture pin, asynchronous |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read has side effects |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| pwm_out | output | 1 | PWM output |
| irq_a | output | 1 | Period-register event pulse |
| irq_b | output | 1 | Duty-register event pulse |

## Verification
A counter that steps wrongly or clears at the wrong value changes the number of `pwm_out` high cycles and `irq_a` pulses within two periods. It also shows up in a counter read-back a few cycles after a known number of ticks. A capture datapath fault shows up in the next read of the value register. A synchroniser of the wrong depth moves the capture interrupt off clock edge k+2, and the bench checks each cycle around that edge. Overrun bookkeeping errors appear on the next status read, as a missing bit or a bit that stays set.

// File: rtl/cct_pkg.sv
package cct_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL   = 3'd0,
    ADR_PERIOD = 3'd1,
    ADR_DUTY   = 3'd2,
    ADR_COUNT  = 3'd3,
    ADR_STATUS = 3'd4
  } cct_addr_e;

  // edge select codes: bit 0 rising, bit 1 falling
  typedef struct packed {
    logic [1:0] edge_b;
    logic [1:0] edge_a;
    logic       cap_b;
    logic       cap_a;
    logic       ext_src;
    logic       run;
  } cct_ctrl_t;

  localparam int CTRL_W = $bits(cct_ctrl_t);

endpackage

// File: rtl/cct_edge_sync.sv
module cct_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  output logic [1:0] edges   // [0] rising, [1] falling
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              lvl;

  assign lvl    = sync_q[STAGES-1];
  assign sync_d = {sync_q[STAGES-2:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= lvl;
    end
  end

  assign edges = {~lvl & last_q, lvl & ~last_q};

endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             period_en,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_top;

  assign at_top = period_en && (cnt_q == period);

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (tick) begin
      if (at_top) cnt_d = '0;
      else        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !(period_en && count == period)) |=> (count == $past(count) + 1'b1)); // R1

  AST_PERIOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && period_en && count == period) |=> (count == '0)); // R4

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val))); // R3

endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_mode,
  input  logic [1:0]       edge_sel,
  input  logic [1:0]       edges,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             rd,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] value,
  output logic             ovf,
  output logic             irq
);

  logic [CNT_W-1:0] val_q, val_d;
  logic             pend_q, pend_d;
  logic             ovf_q, ovf_d;
  logic             irq_q, irq_d;
  logic             cap_evt;

  assign cap_evt = cap_mode && |(edge_sel & edges);

  always_comb begin
    val_d = val_q;
    if (cap_evt)  val_d = count;
    else if (wr)  val_d = wdata;

    pend_d = pend_q;
    if (cap_evt)  pend_d = 1'b1;
    else if (rd)  pend_d = 1'b0;

    ovf_d = ovf_q;
    if (cap_evt && pend_q) ovf_d = 1'b1;
    else if (clr_ovf)      ovf_d = 1'b0;

    irq_d = cap_mode ? cap_evt : (tick && (count == val_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      val_q  <= val_d;
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
      irq_q  <= irq_d;
    end
  end

  assign value = val_q;
  assign ovf   = ovf_q;
  assign irq   = irq_q;

  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (value == $past(count))); // R6

  AST_CAPTURE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> irq); // R7

  AST_NO_OVERFLOW_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && pend_q) |=> ovf); // R8

  AST_MATCH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && tick && count == value) |=> irq); // R10

endmodule

// File: rtl/cc_pwm_timer.sv
module cc_pwm_timer
  import cct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              ext_clk,
  input  logic              cap_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              pwm_out,
  output logic              irq_a,
  output logic              irq_b
);

  localparam int         N_CH     = 2;
  localparam logic [1:0] EXT_MASK = 2'b01;  // count on rising edges only

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // control register
  cct_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en && addr == ADR_CTRL) ctrl_d = cct_ctrl_t'(wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ctrl_q <= '0;
    else            ctrl_q <= ctrl_d;
  end

  // pin synchronisers
  logic [1:0] ext_edges, cap_edges;
  logic       ext_tick, tick;

  cct_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin   (ext_clk),
    .edges (ext_edges)
  );

  cct_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .pin   (cap_in),
    .edges (cap_edges)
  );

  assign ext_tick = |(ext_edges & EXT_MASK);
  assign tick     = ctrl_q.run && (ctrl_q.ext_src ? ext_tick : tick_en);

  // counter
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] ch_val [N_CH];
  logic [N_CH-1:0]  ch_ovf, ch_irq, cap_mode;
  logic [1:0]       edge_sel [N_CH];
  logic             clr_ovf;

  cct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick      (tick),
    .load      (wr_en && addr == ADR_COUNT),
    .load_val  (wdata),
    .period_en (!ctrl_q.cap_a),
    .period    (ch_val[0]),
    .count     (count)
  );

  assign cap_mode    = {ctrl_q.cap_b, ctrl_q.cap_a};
  assign edge_sel[0] = ctrl_q.edge_a;
  assign edge_sel[1] = ctrl_q.edge_b;
  assign clr_ovf     = rd_en && addr == ADR_STATUS;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(int'(ADR_PERIOD) + i);

    cct_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .cap_mode (cap_mode[i]),
      .edge_sel (edge_sel[i]),
      .edges    (cap_edges),
      .tick     (tick),
      .count    (count),
      .wr       (wr_en && addr == MY_ADR),
      .wdata    (wdata),
      .rd       (rd_en && addr == MY_ADR),
      .clr_ovf  (clr_ovf),
      .value    (ch_val[i]),
      .ovf      (ch_ovf[i]),
      .irq      (ch_irq[i])
    );
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      ADR_CTRL:   rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      ADR_PERIOD: rdata = ch_val[0];
      ADR_DUTY:   rdata = ch_val[1];
      ADR_COUNT:  rdata = count;
      ADR_STATUS: rdata = {{(CNT_W-N_CH){1'b0}}, ch_ovf};
      default:    rdata = '0;
    endcase
  end

  assign pwm_out = !ctrl_q.cap_b && (count < ch_val[1]);
  assign irq_a   = ch_irq[0];
  assign irq_b   = ch_irq[1];

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ctrl_q.run && !(wr_en && addr == ADR_COUNT)) |=> $stable(count)); // R1

  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clr_ovf && !(|cap_edges)) |=> (ch_ovf == '0)); // R8

endmodule

// File: tb/cc_pwm_timer_tb.sv
module cc_pwm_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, ext_clk = 1'b0, cap_in = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pwm_out, irq_a, irq_b;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  cc_pwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ext_clk(ext_clk),
    .cap_in(cap_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq_a(irq_a), .irq_b(irq_b)
  );

  typedef struct packed { int a; int b; int hi; int irqb; } vec_t;
  // period, duty, expected high cycles in two periods, expected irq_b pulses
  localparam vec_t VECS [7] = '{
    '{9, 3, 6, 2}, '{9, 0, 0, 2}, '{9, 10, 20, 0}, '{9, 15, 20, 0},
    '{4, 2, 4, 2}, '{0, 1, 2, 0}, '{2, 2, 4, 2}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    rd_en = 1'b1; addr = a;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      ext_clk = 1'b1; wait_n(2);
      ext_clk = 1'b0; wait_n(2);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int v, hi, ia, ib;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);

    // R9 reset state
    chk("R9 pwm_out", int'(pwm_out), 0);
    chk("R9 irq_a", int'(irq_a), 0);
    chk("R9 irq_b", int'(irq_b), 0);
    rd(3'd0, v); chk("R9 ctrl", v, 0);
    rd(3'd3, v); chk("R9 count", v, 0);
    rd(3'd4, v); chk("R9 status", v, 0);
    rd(3'd6, v); chk("R3 unmapped", v, 0);

    // table: R4 period, R5 duty, R10 duty match
    tick_en = 1'b1;
    for (int i = 0; i < 7; i++) begin
      wr(3'd0, 16'h0000);
      wr(3'd1, 16'(VECS[i].a));
      wr(3'd2, 16'(VECS[i].b));
      wr(3'd3, 16'h0000);
      wr(3'd0, 16'h0001);
      wait_n(3);
      hi = 0; ia = 0; ib = 0;
      for (int c = 0; c < 2 * (VECS[i].a + 1); c++) begin
        @(negedge clk);
        hi += int'(pwm_out); ia += int'(irq_a); ib += int'(irq_b);
      end
      chk("R5 high cycles", hi, VECS[i].hi);
      chk("R4 period irq_a", ia, 2);
      chk("R10 duty irq_b", ib, VECS[i].irqb);
    end

    // R5 duty register in capture mode: output low
    wr(3'd2, 16'd50);
    wr(3'd0, 16'h000D);  // run, A and B capture
    hi = 0;
    for (int c = 0; c < 40; c++) begin @(negedge clk); hi += int'(pwm_out); end
    chk("R5 capture-mode low", hi, 0);

    // R2 / R1 internal tick source and hold
    tick_en = 1'b0;
    wr(3'd0, 16'h0005);  // run, internal, A capture
    wr(3'd3, 16'd300);
    wait_n(5);
    rd(3'd3, v); chk("R1 no tick hold", v, 300);
    tick_en = 1'b1; wait_n(10); tick_en = 1'b0;
    rd(3'd3, v); chk("R1 ten ticks", v, 310);
    wr(3'd3, 16'hFFFF);
    tick_en = 1'b1; wait_n(1); tick_en = 1'b0;
    rd(3'd3, v); chk("R1 wrap", v, 0);

    // R2 external source
    tick_en = 1'b1;
    wr(3'd0, 16'h0006);
    wr(3'd3, 16'd200);
    wr(3'd0, 16'h0007);
    wait_n(4);
    rd(3'd3, v); chk("R2 tick_en ignored", v, 200);
    ext_pulses(5); wait_n(4);
    rd(3'd3, v); chk("R2 ext edges", v, 205);
    wr(3'd0, 16'h0006);
    ext_pulses(3); wait_n(4);
    rd(3'd3, v); chk("R1 stopped hold", v, 205);
    tick_en = 1'b0;

    // R6 / R7 capture: A rising, B falling, counter stopped
    wr(3'd2, 16'd7);
    wr(3'd0, 16'h009C);
    wr(3'd3, 16'd1234);
    cap_in = 1'b1;
    @(negedge clk); chk("R7 irq_a edge+0", int'(irq_a), 0);
    @(negedge clk); chk("R7 irq_a edge+1", int'(irq_a), 0);
    @(negedge clk); chk("R7 irq_a edge+2", int'(irq_a), 1);
    chk("R6 irq_b no rise", int'(irq_b), 0);
    @(negedge clk); chk("R7 irq_a one cycle", int'(irq_a), 0);
    rd(3'd1, v); chk("R6 rise capture A", v, 1234);
    rd(3'd2, v); chk("R6 B ignores rise", v, 7);
    wr(3'd3, 16'd555);
    cap_in = 1'b0; wait_n(4);
    rd(3'd2, v); chk("R6 fall capture B", v, 555);
    rd(3'd1, v); chk("R6 A ignores fall", v, 1234);

    // R6 both edges on A
    wr(3'd0, 16'h00BC);
    wr(3'd3, 16'd42);
    cap_in = 1'b1; wait_n(4);
    rd(3'd1, v); chk("R6 both rise", v, 42);
    wr(3'd3, 16'd43);
    cap_in = 1'b0; wait_n(4);
    rd(3'd1, v); chk("R6 both fall", v, 43);

    // R6 no edge selected
    wr(3'd0, 16'h008C);
    wr(3'd3, 16'd99);
    cap_in = 1'b1; wait_n(4); cap_in = 1'b0; wait_n(4);
    rd(3'd1, v); chk("R6 none keeps A", v, 43);

    // R8 overrun
    rd(3'd4, v); rd(3'd1, v); rd(3'd2, v);
    rd(3'd4, v); chk("R8 status clear", v, 0);
    wr(3'd0, 16'h0034);  // A capture both, B compare
    wr(3'd3, 16'd10);
    cap_in = 1'b1; wait_n(4);
    rd(3'd4, v); chk("R8 single capture", v, 0);
    cap_in = 1'b0; wait_n(4);
    rd(3'd4, v); chk("R8 overrun A", v, 1);
    rd(3'd4, v); chk("R8 read clears", v, 0);
    rd(3'd1, v);
    cap_in = 1'b1; wait_n(4);
    rd(3'd4, v); chk("R8 read then capture", v, 0);

    finish_run();
  end

endmodule